// File: doc/BRIEF.md
# Accumulator Processor Control Sequencer

This block is a minimal single-accumulator processor. Instructions and data share one memory. The block reaches that memory through an address output, a write-data output, a read-data input and separate read and write strobes. Inside are a program counter, a memory address register, a memory data register, an instruction register and the accumulator. A control state machine moves data between them one register transfer per clock. It cycles through instruction fetch, decode and a per-opcode execute sequence.

The address and data registers are the only path to the bus. The read and write strobes come only from the control states that own a bus transfer, and every strobe lasts exactly one cycle. Memory is synchronous with one cycle of read latency. After each read strobe the sequencer spends one cycle waiting, then captures the word into the data register. A debug view of the control state and the accumulator lets a bench follow execution instruction by instruction.

Top module: `acc_cpu_seq`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `dbg_state` is 0 (fetch start), `dbg_acc` is 0, `mem_addr` is 0, and both strobes are low.
- R2: One clock after fetch start, `mem_rd` is high for exactly one cycle with `mem_addr` equal to the program counter. The word returned by memory is captured into the data register two cycles after the strobe.
- R3: The program counter starts at 0 and rises by exactly one per instruction fetch, wrapping at the address width. It holds its value at all other times, so the next fetch reads the next sequential address.
- R4: The instruction word is 16 bits: the opcode is bits [15:12] and the operand address is bits [11:0]. Opcode 1 loads memory[address] into the accumulator. Counting from fetch start, the instruction takes 11 cycles, and the accumulator changes at the 11th edge.
- R5: Opcode 3 adds memory[address] to the accumulator modulo 2^16. It also takes 11 cycles.
- R6: Opcode 2 writes the accumulator to memory[address] with one cycle of `mem_wr`. During that cycle `mem_addr` is the address field and `mem_wdata` equals the accumulator. The strobe cycle begins 8 edges after fetch start, the instruction takes 9 cycles, and the accumulator is unchanged.
- R7: Opcode 0 halts: 6 edges after fetch start, `dbg_state` becomes 14. From then until reset the state stays 14, both strobes stay low and `mem_addr` does not change.
- R8: Any opcode other than 0, 1, 2 or 3 does nothing for 6 cycles. Neither the accumulator nor memory is touched, and execution continues at the next address.
- R9: `mem_rd` and `mem_wr` are never high together, and neither stays high for two consecutive cycles.
- R10: A reset asserted in the middle of a program abandons it. Execution restarts at address 0 with a cleared accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data returns one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, driven from the data register |
| mem_rdata | input | 16 | Read data from synchronous memory |
| dbg_state | output | 4 | Current control state code |
| dbg_acc | output | 16 | Current accumulator value |

## Verification
Each result has a fixed edge count measured from fetch start:
- The fetch read strobe appears after 1 edge.
- A load or add changes the accumulator at edge 11.
- A store's write strobe occupies the cycle after edge 8.
- Halt is reached after edge 6, and a no-op returns to fetch after 6 edges.

The bench counts rising edges from reset release and samples on the falling edge right after the edge where a change is due. It also samples one cycle earlier, to show the change did not come too soon. For whole programs, a reference interpreter in the bench adds up the per-opcode cycle costs and computes the final accumulator and memory image. The design must reach the halt state on exactly that cycle count.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_HALT  = 4'd0;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'd2;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'd3;

  // Control states; each moves at most one register across the bus path.
  typedef enum logic [3:0] {
    ST_F_ADDR  = 4'd0,   // MAR <- PC
    ST_F_READ  = 4'd1,   // read strobe
    ST_F_WAIT  = 4'd2,   // memory latency
    ST_F_CAPT  = 4'd3,   // MDR <- bus
    ST_F_IR    = 4'd4,   // CIR <- MDR, PC + 1
    ST_DECODE  = 4'd5,
    ST_X_ADDR  = 4'd6,   // MAR <- CIR address
    ST_X_READ  = 4'd7,
    ST_X_WAIT  = 4'd8,
    ST_X_CAPT  = 4'd9,
    ST_X_LOAD  = 4'd10,  // ACC <- MDR
    ST_X_ADD   = 4'd11,  // ACC <- ACC + MDR
    ST_X_STAGE = 4'd12,  // MDR <- ACC
    ST_X_WRITE = 4'd13,  // write strobe
    ST_HALTED  = 4'd14
  } cpu_state_e;

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output cpu_state_e       state,
  output logic             ld_mar_pc,
  output logic             ld_mar_ir,
  output logic             ld_mdr_bus,
  output logic             ld_mdr_acc,
  output logic             ld_cir,
  output logic             pc_step,
  output logic             ld_acc,
  output logic             alu_add,
  output logic             rd_strobe,
  output logic             wr_strobe
);

  cpu_state_e state_q;
  cpu_state_e state_d;

  function automatic logic is_mem_op(input logic [OPC_W-1:0] op);
    return (op == OPC_LOAD) || (op == OPC_STORE) || (op == OPC_ADD);
  endfunction

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_F_ADDR:  state_d = ST_F_READ;
      ST_F_READ:  state_d = ST_F_WAIT;
      ST_F_WAIT:  state_d = ST_F_CAPT;
      ST_F_CAPT:  state_d = ST_F_IR;
      ST_F_IR:    state_d = ST_DECODE;
      ST_DECODE: begin
        if (is_mem_op(opcode))        state_d = ST_X_ADDR;
        else if (opcode == OPC_HALT)  state_d = ST_HALTED;
        else                          state_d = ST_F_ADDR;
      end
      ST_X_ADDR:  state_d = (opcode == OPC_STORE) ? ST_X_STAGE : ST_X_READ;
      ST_X_READ:  state_d = ST_X_WAIT;
      ST_X_WAIT:  state_d = ST_X_CAPT;
      ST_X_CAPT:  state_d = (opcode == OPC_ADD) ? ST_X_ADD : ST_X_LOAD;
      ST_X_LOAD:  state_d = ST_F_ADDR;
      ST_X_ADD:   state_d = ST_F_ADDR;
      ST_X_STAGE: state_d = ST_X_WRITE;
      ST_X_WRITE: state_d = ST_F_ADDR;
      ST_HALTED:  state_d = ST_HALTED;
      default:    state_d = ST_F_ADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_F_ADDR;
    else     state_q <= state_d;
  end

  always_comb begin
    ld_mar_pc  = 1'b0;
    ld_mar_ir  = 1'b0;
    ld_mdr_bus = 1'b0;
    ld_mdr_acc = 1'b0;
    ld_cir     = 1'b0;
    pc_step    = 1'b0;
    ld_acc     = 1'b0;
    alu_add    = 1'b0;
    rd_strobe  = 1'b0;
    wr_strobe  = 1'b0;
    unique case (state_q)
      ST_F_ADDR:  ld_mar_pc = 1'b1;
      ST_F_READ:  rd_strobe = 1'b1;
      ST_F_CAPT:  ld_mdr_bus = 1'b1;
      ST_F_IR: begin
        ld_cir  = 1'b1;
        pc_step = 1'b1;
      end
      ST_X_ADDR:  ld_mar_ir = 1'b1;
      ST_X_READ:  rd_strobe = 1'b1;
      ST_X_CAPT:  ld_mdr_bus = 1'b1;
      ST_X_LOAD:  ld_acc = 1'b1;
      ST_X_ADD: begin
        ld_acc  = 1'b1;
        alu_add = 1'b1;
      end
      ST_X_STAGE: ld_mdr_acc = 1'b1;
      ST_X_WRITE: wr_strobe = 1'b1;
      default: ;
    endcase
  end

  assign state = state_q;

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] mdr_in,
  input  logic              add_en,
  output logic [DATA_W-1:0] result
);

  // Sum truncated to the accumulator width (wraps on overflow).
  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    logic [DATA_W:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[DATA_W-1:0];
  endfunction

  assign result = add_en ? wrap_add(acc_in, mdr_in) : mdr_in;

endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_mar_pc,
  input  logic              ld_mar_ir,
  input  logic              ld_mdr_bus,
  input  logic              ld_mdr_acc,
  input  logic              ld_cir,
  input  logic              pc_step,
  input  logic              ld_acc,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] alu_y,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] cir,
  output logic [DATA_W-1:0] acc
);

  function automatic logic [ADDR_W-1:0] next_pc(input logic [ADDR_W-1:0] cur);
    return cur + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      cir <= '0;
      acc <= '0;
    end else begin
      if (ld_mar_pc)       mar <= pc;
      else if (ld_mar_ir)  mar <= cir[ADDR_W-1:0];
      if (ld_mdr_bus)      mdr <= bus_rdata;
      else if (ld_mdr_acc) mdr <= acc;
      if (ld_cir)          cir <= mdr;
      if (pc_step)         pc  <= next_pc(pc);
      if (ld_acc)          acc <= alu_y;
    end
  end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DATA_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [3:0]        dbg_state,
  output logic [DATA_W-1:0] dbg_acc
);

  cpu_state_e        state_q;
  logic              ld_mar_pc, ld_mar_ir, ld_mdr_bus, ld_mdr_acc, ld_cir;
  logic              ld_acc, alu_add;
  logic              ev_pc_inc;   // program counter advances this cycle
  logic              ev_mdr_bus;  // data register captures the bus this cycle
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, cir_q, acc_q, alu_y;

  acc_cpu_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .opcode     (cir_q[DATA_W-1 -: OPC_W]),
    .state      (state_q),
    .ld_mar_pc  (ld_mar_pc),
    .ld_mar_ir  (ld_mar_ir),
    .ld_mdr_bus (ev_mdr_bus),
    .ld_mdr_acc (ld_mdr_acc),
    .ld_cir     (ld_cir),
    .pc_step    (ev_pc_inc),
    .ld_acc     (ld_acc),
    .alu_add    (alu_add),
    .rd_strobe  (mem_rd),
    .wr_strobe  (mem_wr)
  );

  assign ld_mdr_bus = ev_mdr_bus;

  acc_cpu_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .ld_mar_pc  (ld_mar_pc),
    .ld_mar_ir  (ld_mar_ir),
    .ld_mdr_bus (ld_mdr_bus),
    .ld_mdr_acc (ld_mdr_acc),
    .ld_cir     (ld_cir),
    .pc_step    (ev_pc_inc),
    .ld_acc     (ld_acc),
    .bus_rdata  (mem_rdata),
    .alu_y      (alu_y),
    .pc         (pc_q),
    .mar        (mar_q),
    .mdr        (mdr_q),
    .cir        (cir_q),
    .acc        (acc_q)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .acc_in (acc_q),
    .mdr_in (mdr_q),
    .add_en (alu_add),
    .result (alu_y)
  );

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign dbg_state = state_q;
  assign dbg_acc   = acc_q;

endmodule

// File: rtl/acc_cpu_seq_chk.sv
module acc_cpu_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        state,
  input logic [DATA_W-1:0] acc,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              ev_pc_inc,
  input logic              ev_mdr_bus
);

  localparam logic [3:0] HALT_CODE = 4'd14;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (state == 4'd0 && acc == '0 && mem_addr == '0 && !mem_rd && !mem_wr)); // R1

  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> ##2 ev_mdr_bus); // R2

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    ev_pc_inc |=> pc == ADDR_W'($past(pc) + 1'b1)); // R3

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ev_pc_inc |=> $stable(pc)); // R3

  AST_STORE_DATA: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_wdata == acc); // R6

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    state == HALT_CODE |=> (state == HALT_CODE && !mem_rd && !mem_wr && $stable(mem_addr))); // R7

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R9

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |=> !(mem_rd || mem_wr)); // R9

endmodule

bind acc_cpu_seq acc_cpu_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .state      (dbg_state),
  .acc        (dbg_acc),
  .pc         (pc_q),
  .mem_addr   (mem_addr),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_wdata  (mem_wdata),
  .ev_pc_inc  (ev_pc_inc),
  .ev_mdr_bus (ev_mdr_bus)
);

// File: tb/acc_cpu_seq_bench.sv
module acc_cpu_seq_bench;

  localparam int AW = 12;
  localparam int DW = 16;
  localparam int MEM_N = 1 << AW;
  localparam logic [3:0] S_FETCH = 4'd0;
  localparam logic [3:0] S_HALT  = 4'd14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [3:0]    dbg_state;
  logic [DW-1:0] dbg_acc;

  logic [DW-1:0] mem     [MEM_N];
  logic [DW-1:0] ref_mem [MEM_N];

  int n_chk = 0;
  int n_bad = 0;
  int strobe_clash = 0;
  int strobe_long  = 0;
  logic prev_strobe = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  acc_cpu_seq u_acc_cpu_seq (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .dbg_state (dbg_state),
    .dbg_acc   (dbg_acc)
  );

  // Synchronous memory, one cycle read latency.
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  // Strobe monitor for R9.
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd && mem_wr) strobe_clash++;
      if (prev_strobe && (mem_rd || mem_wr)) strobe_long++;
      prev_strobe = mem_rd || mem_wr;
    end else begin
      prev_strobe = 1'b0;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < MEM_N; i++) mem[i] = '0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
  endtask

  // Reference interpreter: cycle costs 11 load/add, 9 store, 6 others.
  task automatic ref_run(output logic [DW-1:0] acc, output int cyc);
    logic [AW-1:0] pc;
    logic [DW-1:0] w;
    for (int i = 0; i < MEM_N; i++) ref_mem[i] = mem[i];
    pc = '0; acc = '0; cyc = 0;
    for (int k = 0; k < 2000; k++) begin
      w  = ref_mem[pc];
      pc = pc + 1'b1;
      case (w[15:12])
        4'd1: begin acc = ref_mem[w[11:0]]; cyc += 11; end
        4'd3: begin acc = acc + ref_mem[w[11:0]]; cyc += 11; end
        4'd2: begin ref_mem[w[11:0]] = acc; cyc += 9; end
        4'd0: begin cyc += 6; break; end
        default: cyc += 6;
      endcase
    end
  endtask

  task automatic run_to_halt(output int cyc);
    cyc = 0;
    while (cyc < 20000) begin
      tick(1);
      cyc++;
      if (dbg_state == S_HALT) break;
    end
  endtask

  task automatic run_and_compare(input string req, input string name);
    logic [DW-1:0] exp_acc;
    int exp_cyc, got_cyc, diffs;
    ref_run(exp_acc, exp_cyc);
    do_reset();
    run_to_halt(got_cyc);
    chk(req, {name, " cycles to halt"}, got_cyc, exp_cyc);
    chk(req, {name, " final acc"}, dbg_acc, exp_acc);
    tick(2);
    diffs = 0;
    for (int i = 0; i < MEM_N; i++) if (mem[i] !== ref_mem[i]) diffs++;
    chk(req, {name, " memory image diffs"}, diffs, 0);
  endtask

  task automatic t_reset();
    clear_mem();
    do_reset();
    rst = 1'b1;
    tick(1);
    chk("R1", "state after reset", dbg_state, S_FETCH);
    chk("R1", "acc after reset", dbg_acc, 0);
    chk("R1", "addr after reset", mem_addr, 0);
    chk("R1", "strobes after reset", {mem_rd, mem_wr}, 0);
    rst = 1'b0;
  endtask

  task automatic t_fetch_and_load();
    clear_mem();
    mem[0] = ins(4'd1, 12'h100);
    mem[1] = ins(4'd0, 12'h000);
    mem[12'h100] = 16'hBEEF;
    do_reset();
    tick(1);
    chk("R2", "read strobe one edge after fetch start", mem_rd, 1);
    chk("R2", "fetch address is pc 0", mem_addr, 0);
    tick(1);
    chk("R2", "read strobe single cycle", mem_rd, 0);
    tick(8);
    chk("R4", "acc unchanged before edge 11", dbg_acc, 0);
    tick(1);
    chk("R4", "load result at edge 11", dbg_acc, 16'hBEEF);
    tick(1);
    chk("R3", "second fetch reads next address", {mem_rd, 4'h0, mem_addr}, {1'b1, 4'h0, 12'h001});
  endtask

  task automatic t_store_timing();
    clear_mem();
    mem[0] = ins(4'd1, 12'h080);
    mem[1] = ins(4'd2, 12'h0A5);
    mem[2] = ins(4'd0, 12'h000);
    mem[12'h080] = 16'h1357;
    do_reset();
    tick(18);
    chk("R6", "no write before edge 8 of store", mem_wr, 0);
    tick(1);
    chk("R6", "write strobe at edge 8 of store", mem_wr, 1);
    chk("R6", "write address is field", mem_addr, 12'h0A5);
    chk("R6", "write data is acc", mem_wdata, 16'h1357);
    tick(1);
    chk("R6", "acc unchanged by store", dbg_acc, 16'h1357);
    chk("R6", "write single cycle", mem_wr, 0);
    tick(1);
    chk("R6", "memory written", mem[12'h0A5], 16'h1357);
  endtask

  task automatic t_add_wrap();
    clear_mem();
    mem[0] = ins(4'd1, 12'h200);
    mem[1] = ins(4'd3, 12'h201);
    mem[2] = ins(4'd2, 12'h202);
    mem[3] = ins(4'd0, 12'h000);
    mem[12'h200] = 16'hFFFF;
    mem[12'h201] = 16'h0002;
    do_reset();
    tick(21);
    chk("R5", "acc before add edge", dbg_acc, 16'hFFFF);
    tick(1);
    chk("R5", "add wraps modulo 2^16", dbg_acc, 16'h0001);
    run_and_compare("R5", "add wrap program");
  endtask

  task automatic t_program_mix();
    clear_mem();
    mem[0] = ins(4'd1, 12'h300);
    mem[1] = ins(4'd3, 12'h301);
    mem[2] = ins(4'd7, 12'h300);
    mem[3] = ins(4'd3, 12'h302);
    mem[4] = ins(4'd2, 12'h303);
    mem[5] = ins(4'd3, 12'h303);
    mem[6] = ins(4'd2, 12'hFFF);
    mem[7] = ins(4'd0, 12'h000);
    mem[12'h300] = 16'h0011;
    mem[12'h301] = 16'h0220;
    mem[12'h302] = 16'h3000;
    run_and_compare("R4", "mixed program");
  endtask

  task automatic t_noop();
    clear_mem();
    mem[0] = ins(4'd1, 12'h050);
    mem[1] = ins(4'd9, 12'h050);
    mem[2] = ins(4'd15, 12'h051);
    mem[3] = ins(4'd0, 12'h000);
    mem[12'h050] = 16'h00AA;
    mem[12'h051] = 16'h0055;
    do_reset();
    tick(11 + 6 + 6 + 1);
    chk("R8", "fetch after two no-ops at address 3", {mem_rd, 3'h0, mem_addr}, {1'b1, 3'h0, 12'h003});
    chk("R8", "acc untouched by no-ops", dbg_acc, 16'h00AA);
    run_and_compare("R8", "no-op program");
  endtask

  task automatic t_halt();
    int cyc;
    logic [AW-1:0] a0;
    int bad;
    clear_mem();
    mem[0] = ins(4'd0, 12'h123);
    do_reset();
    run_to_halt(cyc);
    chk("R7", "halt reached after 6 edges", cyc, 6);
    a0 = mem_addr;
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      tick(1);
      if (dbg_state != S_HALT || mem_rd || mem_wr || mem_addr != a0) bad++;
    end
    chk("R7", "halted cycles with activity", bad, 0);
  endtask

  task automatic t_reset_midrun();
    clear_mem();
    mem[0] = ins(4'd1, 12'h400);
    mem[1] = ins(4'd3, 12'h400);
    mem[2] = ins(4'd3, 12'h400);
    mem[3] = ins(4'd2, 12'h401);
    mem[4] = ins(4'd0, 12'h000);
    mem[12'h400] = 16'h0007;
    do_reset();
    tick(15);
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    chk("R10", "state restarted", dbg_state, S_FETCH);
    chk("R10", "acc cleared", dbg_acc, 0);
    tick(1);
    chk("R10", "fetch from address 0", {mem_rd, 3'h0, mem_addr}, {1'b1, 15'h0});
    run_and_compare("R10", "program after restart");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clear_mem();
    t_reset();
    t_fetch_and_load();
    t_store_timing();
    t_add_wrap();
    t_program_mix();
    t_noop();
    t_halt();
    t_reset_midrun();
    chk("R9", "cycles with read and write together", strobe_clash, 0);
    chk("R9", "strobes lasting two cycles", strobe_long, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule